// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order processor core that overlaps up to five instructions at once. The five stages are fetch, decode with register read, execute, memory and write-back, with a pipeline register between each pair. The instruction set covers word loads and stores, branch-if-equal, and register-register and register-immediate integer operations. A new instruction enters fetch on every clock. The program memory and the data memory are separate word arrays, so an instruction fetch and a data access can take place in the same cycle.

Branches are resolved in decode, both the equality test and the target. The register file serves two reads in decode and one write in write-back in every cycle. The core has no hazard detection and no forwarding between stages. Code must therefore be scheduled with NOP padding. A test harness writes the program through a load port while reset is held. It then observes the architectural state through two read-only debug ports, one for a register and one for a data-memory word.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_ni` is low, the PC is 0, every pipeline register holds a bubble, and all registers and data-memory words read as 0. The all-zero instruction word is a NOP.
- R2: Register-register instructions use opcode 0x00, with `rs` at [25:21], `rt` at [20:16] and `rd` at [15:11]. They write `rd` with a function selected by funct [5:0]: 0x20 add, 0x22 sub (rs−rt), 0x24 and, 0x25 or, 0x2A signed set-less-than (1 when rs<rt, else 0).
- R3: Register-immediate instructions write `rt` with a function of `rs` and the sign-extended imm [15:0]. The opcodes are 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or. The immediate is sign-extended for the logical operations too.
- R4: Load (opcode 0x23) writes `rt` with the data word at `rs` + sign-extended imm. Store (opcode 0x2B) writes `rt` to that word. The word index is taken from address bits [DM_AW+1:2], and any higher address bits are dropped.
- R5: Branch-if-equal (opcode 0x04) compares `rs` with `rt` in decode. When they are equal, fetch continues at PC+4+(sign-extended imm<<2). The one instruction that follows a branch always executes, whether or not the branch is taken.
- R6: Register 0 always reads as 0, and writes to it have no effect.
- R7: A register written in write-back can be read by decode in the same cycle. An instruction placed three slots after its producer therefore sees the new value.
- R8: Stores, branches, unknown opcodes and unknown funct values never write a register. Of these, only stores write memory.
- R9: The core issues one instruction per clock. The register write of the instruction at word k takes effect at the (k+5)th rising edge after reset is released, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_we_i | input | 1 | Program memory write strobe |
| imem_waddr_i | input | IM_AW | Program memory word index |
| imem_wdata_i | input | 32 | Program word to write |
| dbg_reg_sel_i | input | 5 | Register to observe |
| dbg_reg_o | output | 32 | Value of selected register |
| dbg_mem_sel_i | input | DM_AW | Data memory word to observe |
| dbg_mem_o | output | 32 | Value of selected data word |

## Verification
The assertions assume that the instruction stream has no unmet dependence. A result is only read by an instruction at least three slots after its producer, and this applies to branch operands too. They also assume that the program memory is written only while reset is low, and that every load and store address is word aligned. The stimulus keeps within these limits. It loads the whole program during reset and places NOPs after the setup writes and after every producer whose result is read soon after. The instructions in the vector table depend only on registers that settled long before. Branches get a NOP or an observable write in their delay slot, and every effective address is a multiple of four.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_re;
    logic    mem_we;
    logic    use_imm;
    alu_op_e alu_op;
  } ctrl_t;

  typedef struct packed {
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] pc4;
  } ifid_t;

  typedef struct packed {
    ctrl_t           ctrl;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] imm;
    logic [RAW-1:0]  dst;
  } idex_t;

  typedef struct packed {
    logic            reg_we;
    logic            mem_re;
    logic            mem_we;
    logic [XLEN-1:0] y;
    logic [XLEN-1:0] sdata;
    logic [RAW-1:0]  dst;
  } exmem_t;

  typedef struct packed {
    logic            reg_we;
    logic [XLEN-1:0] result;
    logic [RAW-1:0]  dst;
  } memwb_t;
endpackage

// File: rtl/pipe5_decoder.sv
module pipe5_decoder
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o,
  output logic       dst_rt_o,
  output logic       branch_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    dst_rt_o      = 1'b0;
    branch_o      = 1'b0;
    case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_we = 1'b1;
        case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.reg_we = 1'b0;
        endcase
      end
      OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        dst_rt_o       = 1'b1;
        case (opcode_i)
          OP_SLTI: ctrl_o.alu_op = ALU_SLT;
          OP_ANDI: ctrl_o.alu_op = ALU_AND;
          OP_ORI:  ctrl_o.alu_op = ALU_OR;
          default: ctrl_o.alu_op = ALU_ADD;
        endcase
      end
      OP_LW: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.mem_re  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        dst_rt_o       = 1'b1;
      end
      OP_SW: begin
        ctrl_o.mem_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_BEQ:  branch_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter  int NREG = 32,
  parameter  int XLEN = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  input  logic [AW-1:0]   rdbg_i,
  output logic [XLEN-1:0] qa_o,
  output logic [XLEN-1:0] qb_o,
  output logic [XLEN-1:0] qdbg_o
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // write-back value wins over the stored copy for decode reads
  logic [AW-1:0]   rd_addr [2];
  logic [XLEN-1:0] rd_data [2];
  assign rd_addr[0] = ra_i;
  assign rd_addr[1] = rb_i;

  for (genvar p = 0; p < 2; p++) begin : g_rport
    always_comb begin
      if (rd_addr[p] == '0)                    rd_data[p] = '0;
      else if (we_i && waddr_i == rd_addr[p])  rd_data[p] = wdata_i;
      else                                     rd_data[p] = regs_q[rd_addr[p]];
    end
  end

  assign qa_o   = rd_data[0];
  assign qb_o   = rd_data[1];
  assign qdbg_o = (rdbg_i == '0) ? '0 : regs_q[rdbg_i];
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IM_AW      = $clog2(IMEM_WORDS),
  localparam int DM_AW      = $clog2(DMEM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             imem_we_i,
  input  logic [IM_AW-1:0] imem_waddr_i,
  input  logic [31:0]      imem_wdata_i,
  input  logic [4:0]       dbg_reg_sel_i,
  output logic [31:0]      dbg_reg_o,
  input  logic [DM_AW-1:0] dbg_mem_sel_i,
  output logic [31:0]      dbg_mem_o
);
  // ---------------- fetch
  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, fetch_instr;
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic            br_taken;
  logic [XLEN-1:0] br_target;
  ifid_t           ifid_q;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_waddr_i] <= imem_wdata_i;
  end

  assign fetch_instr = imem[pc_q[IM_AW+1:2]];
  assign pc_plus4    = pc_q + XLEN'(4);
  assign pc_next     = br_taken ? br_target : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      ifid_q <= '0;
    end else begin
      pc_q   <= pc_next;
      ifid_q <= '{instr: fetch_instr, pc4: pc_plus4};
    end
  end

  // ---------------- decode / register read
  logic [RAW-1:0]  id_rs, id_rt, id_rd;
  logic [XLEN-1:0] id_imm, id_rs_val, id_rt_val;
  ctrl_t           id_ctrl;
  logic            id_dst_rt, id_branch;
  logic            wb_we;
  logic [RAW-1:0]  wb_addr;
  logic [XLEN-1:0] wb_data;
  idex_t           idex_q;

  assign id_rs  = ifid_q.instr[25:21];
  assign id_rt  = ifid_q.instr[20:16];
  assign id_rd  = ifid_q.instr[15:11];
  assign id_imm = {{(XLEN-16){ifid_q.instr[15]}}, ifid_q.instr[15:0]};

  pipe5_decoder u_dec (
    .opcode_i (ifid_q.instr[31:26]),
    .funct_i  (ifid_q.instr[5:0]),
    .ctrl_o   (id_ctrl),
    .dst_rt_o (id_dst_rt),
    .branch_o (id_branch)
  );

  pipe5_regfile #(.NREG(1 << RAW), .XLEN(XLEN)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wb_we),
    .waddr_i (wb_addr),
    .wdata_i (wb_data),
    .ra_i    (id_rs),
    .rb_i    (id_rt),
    .rdbg_i  (dbg_reg_sel_i),
    .qa_o    (id_rs_val),
    .qb_o    (id_rt_val),
    .qdbg_o  (dbg_reg_o)
  );

  assign br_taken  = id_branch && (id_rs_val == id_rt_val);
  assign br_target = ifid_q.pc4 + (id_imm << 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idex_q <= '0;
    end else begin
      idex_q <= '{ctrl: id_ctrl, a: id_rs_val, b: id_rt_val, imm: id_imm,
                  dst: id_dst_rt ? id_rt : id_rd};
    end
  end

  // ---------------- execute
  logic [XLEN-1:0] ex_opb, ex_y;
  exmem_t          exm_q;

  assign ex_opb = idex_q.ctrl.use_imm ? idex_q.imm : idex_q.b;

  pipe5_alu u_alu (
    .op_i (idex_q.ctrl.alu_op),
    .a_i  (idex_q.a),
    .b_i  (ex_opb),
    .y_o  (ex_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exm_q <= '0;
    end else begin
      exm_q <= '{reg_we: idex_q.ctrl.reg_we, mem_re: idex_q.ctrl.mem_re,
                 mem_we: idex_q.ctrl.mem_we, y: ex_y, sdata: idex_q.b,
                 dst: idex_q.dst};
    end
  end

  // ---------------- memory
  logic [XLEN-1:0]  dmem [DMEM_WORDS];
  logic [DM_AW-1:0] dm_idx;
  logic [XLEN-1:0]  dm_rdata;
  memwb_t           mwb_q;

  assign dm_idx   = exm_q.y[DM_AW+1:2];
  assign dm_rdata = dmem[dm_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
    end else if (exm_q.mem_we) begin
      dmem[dm_idx] <= exm_q.sdata;
    end
  end

  assign dbg_mem_o = dmem[dbg_mem_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mwb_q <= '0;
    end else begin
      mwb_q <= '{reg_we: exm_q.reg_we,
                 result: exm_q.mem_re ? dm_rdata : exm_q.y,
                 dst: exm_q.dst};
    end
  end

  // ---------------- write-back
  assign wb_we   = mwb_q.reg_we;
  assign wb_addr = mwb_q.dst;
  assign wb_data = mwb_q.result;

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IM_AW+2], ifid_q.instr[10:6],
                         exm_q.y[1:0], exm_q.y[XLEN-1:DM_AW+2]};
endmodule

// File: rtl/pipe5_checker.sv
module pipe5_checker
  import pipe5_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_q,
  input logic            br_taken,
  input logic [XLEN-1:0] br_target,
  input logic            exm_reg_we,
  input logic            exm_mem_we,
  input logic            exm_mem_re,
  input logic [XLEN-1:0] dm_rdata,
  input logic [XLEN-1:0] mwb_result,
  input logic            wb_we,
  input logic [RAW-1:0]  wb_addr,
  input logic [XLEN-1:0] wb_data,
  input logic [RAW-1:0]  id_rs,
  input logic [XLEN-1:0] id_rs_val
);
  assert_pc_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_taken |=> pc_q == $past(pc_q) + XLEN'(4))
    else $error("pc did not advance by one word");

  assert_branch_redirect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken |=> pc_q == $past(br_target))
    else $error("taken branch did not redirect fetch");

  assert_store_no_regwrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exm_mem_we |-> !exm_reg_we)
    else $error("store carries a register write");

  assert_load_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exm_mem_re |=> mwb_result == $past(dm_rdata))
    else $error("load result differs from memory word");

  assert_wb_visible_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_we && wb_addr == id_rs && id_rs != '0) |-> id_rs_val == wb_data)
    else $error("decode read missed same-cycle write");

  assert_r0_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs == '0) |-> id_rs_val == '0)
    else $error("register 0 read nonzero");
endmodule

bind pipe5_core pipe5_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_q       (pc_q),
  .br_taken   (br_taken),
  .br_target  (br_target),
  .exm_reg_we (exm_q.reg_we),
  .exm_mem_we (exm_q.mem_we),
  .exm_mem_re (exm_q.mem_re),
  .dm_rdata   (dm_rdata),
  .mwb_result (mwb_q.result),
  .wb_we      (wb_we),
  .wb_addr    (wb_addr),
  .wb_data    (wb_data),
  .id_rs      (id_rs),
  .id_rs_val  (id_rs_val)
);

// File: tb/pipe5_core_test.sv
module pipe5_core_test;
  localparam int PERIOD = 10;
  localparam int IMW    = 64;
  localparam int DMW    = 64;
  localparam int IAW    = $clog2(IMW);
  localparam int DAW    = $clog2(DMW);

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rd,
                                        input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rt,
                                        input logic [4:0] rs, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  localparam int NVEC = 12;
  localparam logic [31:0] VEC_INS [NVEC] = '{
    enc_r(6'h20, 5'd10, 5'd1, 5'd2),
    enc_r(6'h22, 5'd11, 5'd1, 5'd2),
    enc_r(6'h24, 5'd12, 5'd2, 5'd3),
    enc_r(6'h25, 5'd13, 5'd1, 5'd3),
    enc_r(6'h2A, 5'd14, 5'd2, 5'd1),
    enc_r(6'h2A, 5'd15, 5'd1, 5'd2),
    enc_i(6'h08, 5'd16, 5'd1, 16'hFFF8),
    enc_i(6'h0A, 5'd17, 5'd1, 16'h0008),
    enc_i(6'h0C, 5'd18, 5'd3, 16'h0030),
    enc_i(6'h0D, 5'd19, 5'd1, 16'h8000),
    enc_i(6'h0A, 5'd20, 5'd2, 16'hFFFC),
    enc_r(6'h22, 5'd21, 5'd2, 5'd1)
  };
  localparam logic [4:0] VEC_RD [NVEC] = '{
    5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15,
    5'd16, 5'd17, 5'd18, 5'd19, 5'd20, 5'd21
  };
  localparam logic [31:0] VEC_EXP [NVEC] = '{
    32'h0000_0004, 32'h0000_000A, 32'h0000_00F0, 32'h0000_00F7,
    32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001,
    32'h0000_0030, 32'hFFFF_8007, 32'h0000_0000, 32'hFFFF_FFF6
  };
  localparam logic [NVEC-1:0] VEC_IMM = 12'b0111_1100_0000;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b1;
  logic           imem_we_i = 1'b0;
  logic [IAW-1:0] imem_waddr_i = '0;
  logic [31:0]    imem_wdata_i = '0;
  logic [4:0]     dbg_reg_sel_i = '0;
  logic [31:0]    dbg_reg_o;
  logic [DAW-1:0] dbg_mem_sel_i = '0;
  logic [31:0]    dbg_mem_o;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  logic [31:0] prog [IMW];

  always #(PERIOD/2) clk_i = ~clk_i;

  pipe5_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) uut (
    .clk_i, .rst_ni, .imem_we_i, .imem_waddr_i, .imem_wdata_i,
    .dbg_reg_sel_i, .dbg_reg_o, .dbg_mem_sel_i, .dbg_mem_o
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic peek_reg(input logic [4:0] r, output logic [31:0] v);
    dbg_reg_sel_i = r;
    #1 v = dbg_reg_o;
  endtask

  task automatic peek_mem(input logic [DAW-1:0] w, output logic [31:0] v);
    dbg_mem_sel_i = w;
    #1 v = dbg_mem_o;
  endtask

  initial begin
    #(PERIOD * 2000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < IMW; i++) prog[i] = 32'h0;
    prog[0] = enc_i(6'h08, 5'd1, 5'd0, 16'd7);
    prog[1] = enc_i(6'h08, 5'd2, 5'd0, 16'hFFFD);
    prog[2] = enc_i(6'h08, 5'd3, 5'd0, 16'h00F0);
    for (int i = 0; i < NVEC; i++) prog[5 + i] = VEC_INS[i];
    prog[17] = enc_i(6'h08, 5'd0, 5'd0, 16'd5);        // write to r0
    prog[18] = enc_i(6'h08, 5'd31, 5'd0, 16'h0055);
    prog[21] = enc_r(6'h20, 5'd9, 5'd31, 5'd0);         // three slots after producer
    prog[22] = enc_r(6'h20, 5'd22, 5'd0, 5'd1);
    prog[23] = enc_i(6'h2B, 5'd2, 5'd0, 16'd12);        // word 3
    prog[24] = enc_i(6'h2B, 5'd3, 5'd3, 16'hFF18);      // 0xF0-232 = word 2
    prog[25] = enc_i(6'h23, 5'd23, 5'd0, 16'd12);
    prog[26] = enc_i(6'h23, 5'd24, 5'd3, 16'hFF18);
    prog[27] = enc_i(6'h2B, 5'd1, 5'd3, 16'hE800);      // rd field 29, word 60
    prog[28] = enc_i(6'h3F, 5'd30, 5'd1, 16'hF000);     // unknown opcode, rd field 30
    prog[29] = enc_i(6'h04, 5'd1, 5'd1, 16'd2);         // taken -> 32
    prog[30] = enc_i(6'h08, 5'd25, 5'd0, 16'd1);        // delay slot
    prog[31] = enc_i(6'h08, 5'd26, 5'd0, 16'd1);        // skipped
    prog[32] = enc_i(6'h08, 5'd27, 5'd0, 16'd1);
    prog[33] = enc_i(6'h04, 5'd2, 5'd1, 16'd3);         // not taken
    prog[35] = enc_i(6'h08, 5'd28, 5'd0, 16'd2);
    prog[38] = enc_i(6'h08, 5'd8, 5'd0, 16'h0077);

    #1 rst_ni = 1'b0;
    for (int i = 0; i < IMW; i++) begin
      @(negedge clk_i);
      imem_we_i    = 1'b1;
      imem_waddr_i = IAW'(i);
      imem_wdata_i = prog[i];
    end
    @(negedge clk_i);
    imem_we_i = 1'b0;

    // reset state (R1)
    peek_reg(5'd1, v);   check("R1", "r1 in reset", v, 32'h0);
    peek_mem(DAW'(3), v); check("R1", "mem3 in reset", v, 32'h0);

    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    peek_reg(5'd1, v);   check("R9", "r1 after 4 edges", v, 32'h0);
    @(posedge clk_i);
    @(negedge clk_i);
    peek_reg(5'd1, v);   check("R9", "r1 after 5 edges", v, 32'h7);

    repeat (60) @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      peek_reg(VEC_RD[i], v);
      check(VEC_IMM[i] ? "R3" : "R2", $sformatf("vector %0d", i), v, VEC_EXP[i]);
    end

    peek_reg(5'd0, v);    check("R6", "r0 after write", v, 32'h0);
    peek_reg(5'd22, v);   check("R6", "r0 as operand", v, 32'h7);
    peek_reg(5'd9, v);    check("R7", "same-cycle read", v, 32'h55);
    peek_mem(DAW'(3), v); check("R4", "store word 3", v, 32'hFFFF_FFFD);
    peek_mem(DAW'(2), v); check("R4", "store negative offset", v, 32'hF0);
    peek_reg(5'd23, v);   check("R4", "load word 3", v, 32'hFFFF_FFFD);
    peek_reg(5'd24, v);   check("R4", "load negative offset", v, 32'hF0);
    peek_mem(DAW'(60), v); check("R4", "store high bits dropped", v, 32'h7);
    peek_reg(5'd29, v);   check("R8", "store no reg write", v, 32'h0);
    peek_reg(5'd30, v);   check("R8", "unknown opcode no write", v, 32'h0);
    peek_reg(5'd25, v);   check("R5", "delay slot runs", v, 32'h1);
    peek_reg(5'd26, v);   check("R5", "skipped by branch", v, 32'h0);
    peek_reg(5'd27, v);   check("R5", "branch target", v, 32'h1);
    peek_reg(5'd28, v);   check("R5", "not-taken falls through", v, 32'h2);
    peek_reg(5'd8, v);    check("R5", "after branches", v, 32'h77);
    peek_reg(5'd1, v);    check("R8", "branch leaves rt", v, 32'h7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule